// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous memory with registered address, control and write-data inputs and a registered read output. An access begins when one of two address strobes is asserted: the processor strobe or the controller strobe. The strobe loads the presented address into an internal two-bit burst counter. The burst then continues one beat per clock while the step input is held low, for four beats in all before the counter wraps. The order of the beats is either linear or interleaved, chosen by a mode input. Each lane of the data word carries eight data bits and a parity bit. Writes can be masked per lane, or a global write can force every lane to be written.

Read data is pipelined by one stage: a beat registered on one rising edge appears at the output after the next rising edge. The output drive flag stands in for the pad's output buffer. It is asserted only for read beats while output enable is low. A strobe sampled while the chip is not fully selected ends the burst, and the output stops driving one cycle later. A sleep input blocks all strobes and accesses and keeps both the array and the burst position. It also cuts the output drive at once, without waiting for a clock.

Top module: `psram_burst`

## Requirements
- R1: On the edge where a strobe is sampled with all three enables active (en_n low, en_hi high, en_lo_n low), the address is loaded, and the data of that word appears on rdata after the following rising edge.
- R2: While a burst is active and no strobe is present, step_n low moves to the next beat on each edge. step_n high repeats the current beat's address (suspend).
- R3: With order_ilv low (linear), the two low address bits of beat k are (start + k) mod 4.
- R4: With order_ilv high (interleaved), the two low address bits of beat k are start XOR k. In both orders the upper address bits stay at the loaded value, and the counter wraps so that beat 4 uses the address of beat 0.
- R5: all_wr_n low on a beat writes every lane, whatever lane_sel_n holds.
- R6: With all_wr_n high, lane_wr_n low and lane_sel_n[i] low write lane i only. Lane i occupies bits [9i+8:9i] of wdata and rdata, with the parity bit at 9i+8. Unselected lanes keep their contents.
- R7: A beat started by the processor strobe, or by both strobes together, is always a read, and the write inputs are ignored. A beat started by the controller strobe obeys the write inputs.
- R8: rdata_drive is high only after a read beat and only while out_en_n is low. out_en_n acts without a clock. A write beat leaves the output undriven after the next edge.
- R9: A strobe sampled while any enable is inactive ends the burst. rdata_drive is low after the second edge from that sample (single-cycle deselect).
- R10: While sleep is high, strobes and step are ignored, no access takes place, and the array and the burst position are kept. rdata_drive drops at once.
- R11: After reset no burst is active and rdata_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sleep | input | 1 | Power-down; blocks access, holds state |
| en_n | input | 1 | Chip enable, active low |
| en_hi | input | 1 | Chip select, active high |
| en_lo_n | input | 1 | Chip select, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drive | output | 1 | High when the output would be driven |

## Verification
A write beat finishing in the array and a read strobe to the same word can fall on the same edge. The bench provokes this by issuing a controller-strobe global write and then, on the very next cycle, a processor strobe to the same address. The returned word must be the freshly written one. A second overlap occurs when sleep is raised in the middle of a burst while step_n stays low. Once sleep falls, the next beat must come from the held counter position, with no beat skipped.

// File: rtl/psb_pkg.sv
package psb_pkg;
   localparam int unsigned BEATS = 4;

   // low two address bits of beat k for a given start and order
   function automatic logic [1:0] psb_beat_low(input logic [1:0] start,
                                               input logic [1:0] k,
                                               input logic ilv);
      return ilv ? (start ^ k) : (start + k);
   endfunction
endpackage

// File: rtl/psb_burst_ctl.sv
module psb_burst_ctl
   import psb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              sel_ok,
   input  logic              proc_stb,
   input  logic              ctrl_stb,
   input  logic              step,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              all_wr,
   input  logic              lane_wr,
   input  logic [LANES-1:0]  lane_sel,
   output logic              acc_valid,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  acc_mask
);
   logic              active;
   logic [ADDR_W-1:0] base;
   logic [1:0]        cnt;
   logic              strobe;
   logic [LANES-1:0]  mask_c;
   logic              wr_c;
   logic [1:0]        nxt_cnt;

   always_comb begin
      strobe  = (proc_stb | ctrl_stb) & ~sleep;
      mask_c  = all_wr ? {LANES{1'b1}} : (lane_wr ? lane_sel : {LANES{1'b0}});
      wr_c    = |mask_c;
      nxt_cnt = step ? cnt + 2'd1 : cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         base      <= '0;
         cnt       <= 2'd0;
         acc_valid <= 1'b0;
         acc_wr    <= 1'b0;
         acc_addr  <= '0;
         acc_mask  <= '0;
      end else if (sleep) begin
         acc_valid <= 1'b0;
      end else if (strobe && !sel_ok) begin
         active    <= 1'b0;
         acc_valid <= 1'b0;
      end else if (strobe) begin
         active    <= 1'b1;
         base      <= addr;
         cnt       <= 2'd0;
         acc_valid <= 1'b1;
         acc_addr  <= addr;
         acc_wr    <= proc_stb ? 1'b0 : wr_c;
         acc_mask  <= mask_c;
      end else if (active) begin
         cnt       <= nxt_cnt;
         acc_valid <= 1'b1;
         acc_addr  <= {base[ADDR_W-1:2], psb_beat_low(base[1:0], nxt_cnt, order_ilv)};
         acc_wr    <= wr_c;
         acc_mask  <= mask_c;
      end else begin
         acc_valid <= 1'b0;
      end
   end

   assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(cnt) && $stable(active) && !acc_valid));

   assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sleep && !proc_stb && !ctrl_stb)
         |=> (acc_addr[ADDR_W-1:2] == $past(base[ADDR_W-1:2])));

   assert_proc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_stb && !sleep && sel_ok) |=> !acc_wr);
endmodule

// File: rtl/psb_lane_ram.sv
module psb_lane_ram #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] q
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wd;
      if (re) q <= mem[addr];
   end
endmodule

// File: rtl/psram_burst.sv
module psram_burst #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep,
   input  logic                    en_n,
   input  logic                    en_hi,
   input  logic                    en_lo_n,
   input  logic                    proc_stb_n,
   input  logic                    ctrl_stb_n,
   input  logic                    step_n,
   input  logic                    order_ilv,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    out_en_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_drive
);
   localparam int unsigned DW = LANES * LANE_W;

   generate
      if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
         $error("psram_burst: LANES must be 2 or 4");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("psram_burst: ADDR_W must cover a four-beat burst");
      end
   endgenerate

   logic              sel_ok;
   logic              acc_valid, acc_wr;
   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  acc_mask;
   logic [DW-1:0]     wdat_q;
   logic              out_valid_q;

   assign sel_ok = ~en_n & en_hi & ~en_lo_n;

   psb_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (sleep),
      .sel_ok    (sel_ok),
      .proc_stb  (~proc_stb_n),
      .ctrl_stb  (~ctrl_stb_n),
      .step      (~step_n),
      .order_ilv (order_ilv),
      .addr      (addr),
      .all_wr    (~all_wr_n),
      .lane_wr   (~lane_wr_n),
      .lane_sel  (~lane_sel_n),
      .acc_valid (acc_valid),
      .acc_wr    (acc_wr),
      .acc_addr  (acc_addr),
      .acc_mask  (acc_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdat_q      <= '0;
         out_valid_q <= 1'b0;
      end else begin
         wdat_q      <= wdata;
         out_valid_q <= acc_valid & ~acc_wr;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      psb_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk  (clk),
         .we   (acc_valid & acc_wr & acc_mask[g]),
         .re   (acc_valid & ~acc_wr),
         .addr (acc_addr),
         .wd   (wdat_q[g*LANE_W +: LANE_W]),
         .q    (rdata[g*LANE_W +: LANE_W])
      );
   end

   assign rdata_drive = out_valid_q & ~out_en_n & ~sleep;

   assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr) |=> !rdata_drive);

   assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!proc_stb_n || !ctrl_stb_n) && !sel_ok) |=> ##1 !rdata_drive);
endmodule

// File: tb/sim_psram_burst.sv
`timescale 1ns/1ps
module sim_psram_burst;
   localparam int AW = 8;
   localparam int L  = 4;
   localparam int LW = 9;
   localparam int DW = L * LW;

   logic clk = 1'b0;
   logic rst_n, sleep, en_n, en_hi, en_lo_n, proc_stb_n, ctrl_stb_n, step_n;
   logic order_ilv, all_wr_n, lane_wr_n, out_en_n, rdata_drive;
   logic [AW-1:0] addr;
   logic [L-1:0]  lane_sel_n;
   logic [DW-1:0] wdata, rdata;

   logic [DW-1:0] ref_mem [0:(1<<AW)-1];
   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   psram_burst #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .en_n(en_n), .en_hi(en_hi),
      .en_lo_n(en_lo_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .step_n(step_n), .order_ilv(order_ilv), .addr(addr), .all_wr_n(all_wr_n),
      .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
      .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
   );

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_in();
      sleep = 0; en_n = 0; en_hi = 1; en_lo_n = 0;
      proc_stb_n = 1; ctrl_stb_n = 1; step_n = 1;
      all_wr_n = 1; lane_wr_n = 1; lane_sel_n = '1; out_en_n = 0;
   endtask

   function automatic logic [AW-1:0] beat(input logic [AW-1:0] s, input int k, input logic ilv);
      logic [1:0] kk = 2'(k);
      return {s[AW-1:2], ilv ? (s[1:0] ^ kk) : (s[1:0] + kk)};
   endfunction

   task automatic deselect();
      all_wr_n = 1; lane_wr_n = 1; step_n = 1;
      ctrl_stb_n = 0; en_n = 1;
      cyc();
      ctrl_stb_n = 1; en_n = 0;
      cyc();
   endtask

   // write four beats from controller strobe; global selects all-lane write
   task automatic write_burst(input logic [AW-1:0] a, input logic ilv, input bit global);
      order_ilv = ilv;
      for (int k = 0; k < 4; k++) begin
         logic [DW-1:0] d = {$urandom(), $urandom()};
         logic [L-1:0]  m = 4'($urandom_range(1, 15));
         logic [AW-1:0] ba = beat(a, k, ilv);
         if (k == 0) begin ctrl_stb_n = 0; addr = a; step_n = 1; end
         else begin ctrl_stb_n = 1; step_n = 0; end
         wdata = d;
         if (global) begin all_wr_n = 0; lane_wr_n = 1; lane_sel_n = 4'($urandom()); end
         else begin all_wr_n = 1; lane_wr_n = 0; lane_sel_n = ~m; end
         cyc();
         for (int l = 0; l < L; l++)
            if (global || m[l]) ref_mem[ba][l*LW +: LW] = d[l*LW +: LW];
         if (k > 0) chk("R8 write beat leaves output undriven", {35'd0, rdata_drive}, 0);
      end
      deselect();
   endtask

   task automatic read_burst(input logic [AW-1:0] a, input logic ilv, input int n, input string req);
      order_ilv = ilv;
      proc_stb_n = 0; addr = a; step_n = 1;
      cyc();
      proc_stb_n = 1; step_n = 0;
      for (int k = 0; k < n; k++) begin
         cyc();
         chk(req, rdata, ref_mem[beat(a, k, ilv)]);
      end
      chk("R8 read beat drives", {35'd0, rdata_drive}, 1);
      deselect();
   endtask

   task automatic t_reset();
      chk("R11 reset: output undriven", {35'd0, rdata_drive}, 0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < (1<<AW); a += 4) write_burst(AW'(a), 1'b0, 1'b1);
      read_burst(8'h40, 1'b0, 4, "R5 global write fills all lanes");
   endtask

   task automatic t_linear();
      write_burst(8'h12, 1'b0, 1'b0);
      read_burst(8'h12, 1'b0, 4, "R3 linear order, R6 lane mask");
      read_burst(8'h33, 1'b0, 6, "R4 wrap after four beats (linear) R1");
   endtask

   task automatic t_interleave();
      write_burst(8'h25, 1'b1, 1'b0);
      read_burst(8'h25, 1'b1, 4, "R4 interleaved order, R6 lane mask");
      read_burst(8'h27, 1'b1, 4, "R4 interleaved from offset 3");
      write_burst(8'h6a, 1'b1, 1'b1);
      read_burst(8'h6a, 1'b0, 4, "R5 global write ignores lane selects");
   endtask

   task automatic t_suspend();
      order_ilv = 0;
      proc_stb_n = 0; addr = 8'h51; step_n = 1;
      cyc();
      proc_stb_n = 1;
      cyc();
      chk("R1 first beat after one edge", rdata, ref_mem[8'h51]);
      step_n = 0;
      cyc();
      chk("R2 suspended beat repeats", rdata, ref_mem[8'h51]);
      cyc();
      chk("R2 advance after suspend", rdata, ref_mem[8'h52]);
      deselect();
   endtask

   task automatic t_proc_ignores_write();
      logic [DW-1:0] old = ref_mem[8'h80];
      proc_stb_n = 0; addr = 8'h80; all_wr_n = 0; wdata = ~old;
      cyc();
      proc_stb_n = 1; all_wr_n = 1; step_n = 1;
      cyc();
      chk("R7 processor strobe reads, write ignored", rdata, old);
      deselect();
      proc_stb_n = 0; ctrl_stb_n = 0; addr = 8'h81; all_wr_n = 0; wdata = ~ref_mem[8'h81];
      cyc();
      proc_stb_n = 1; ctrl_stb_n = 1; all_wr_n = 1;
      cyc();
      chk("R7 both strobes: read", rdata, ref_mem[8'h81]);
      deselect();
      read_burst(8'h80, 1'b0, 2, "R7 array unchanged after processor strobe");
   endtask

   task automatic t_deselect_oe();
      proc_stb_n = 0; addr = 8'h90;
      cyc();
      proc_stb_n = 1;
      cyc();
      chk("R8 drive on read", {35'd0, rdata_drive}, 1);
      out_en_n = 1; #1;
      chk("R8 out_en_n high stops drive at once", {35'd0, rdata_drive}, 0);
      out_en_n = 0; #1;
      ctrl_stb_n = 0; en_hi = 0;
      cyc();
      chk("R9 still driving one edge after deselect sample", {35'd0, rdata_drive}, 1);
      ctrl_stb_n = 1; en_hi = 1;
      cyc();
      chk("R9 undriven after second edge", {35'd0, rdata_drive}, 0);
      cyc();
      chk("R9 burst stays ended", {35'd0, rdata_drive}, 0);
   endtask

   task automatic t_sleep();
      logic [DW-1:0] old = ref_mem[8'ha0];
      sleep = 1; ctrl_stb_n = 0; addr = 8'ha0; all_wr_n = 0; wdata = ~old;
      cyc();
      chk("R10 no access during sleep", {35'd0, rdata_drive}, 0);
      sleep = 0; ctrl_stb_n = 1; all_wr_n = 1;
      cyc();
      read_burst(8'ha0, 1'b0, 1, "R10 strobe ignored, array kept");
      order_ilv = 0;
      proc_stb_n = 0; addr = 8'hb0; step_n = 1;
      cyc();
      proc_stb_n = 1; step_n = 0;
      cyc();
      chk("R1 beat0 before sleep", rdata, ref_mem[8'hb0]);
      sleep = 1; #1;
      chk("R10 sleep cuts drive at once", {35'd0, rdata_drive}, 0);
      cyc(); cyc();
      sleep = 0;
      cyc(); cyc();
      chk("R10 burst position kept across sleep", rdata, ref_mem[8'hb2]);
      deselect();
   endtask

   task automatic t_write_then_read();
      logic [DW-1:0] d = {$urandom(), $urandom()};
      ctrl_stb_n = 0; addr = 8'hc4; all_wr_n = 0; wdata = d;
      cyc();
      ref_mem[8'hc4] = d;
      ctrl_stb_n = 1; all_wr_n = 1; proc_stb_n = 0;
      cyc();
      proc_stb_n = 1; step_n = 1;
      cyc();
      chk("R1 read right behind write sees new data", rdata, d);
      deselect();
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      idle_in(); order_ilv = 0; addr = '0; wdata = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      t_reset();
      t_fill();
      t_linear();
      t_interleave();
      t_suspend();
      t_proc_ignores_write();
      t_deselect_oe();
      t_sleep();
      t_write_then_read();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule